// File: doc/BRIEF.md
# Legacy Peripheral Write Timing Bridge

This block sits between a host bus that signals reads and writes through two separate request/acknowledge pairs and an older byte-wide peripheral that expects a plain address bus, a data bus, a chip select and active-high read and write strobes. When the host raises a request, the bridge registers the address, write data and chip select. It then plays out the peripheral's access timing and returns an acknowledge once that timing is met. The peripheral's reset is the bridge's reset, passed straight through.

Write timing comes entirely from taps of one six-stage shift register whose serial input is the accepted write request. One group of taps forms the write strobe. The stage after that group is the acknowledge. The strobe starts one cycle after the address and data reach the peripheral. It stays high for four cycles. Address and data then stay stable for one more cycle, which is the acknowledge cycle. Reads use a second shift register whose length is a parameter. It produces a read strobe, captures the peripheral's read data in the cycle before the read acknowledge, and holds that data until the next read. A parameter selects either a strobe decoded directly from the taps or a strobe taken from a flip-flop (glitch-free). Both choices give the same cycle timing.

The handshake has no ready signal. A request is a one-cycle pulse. The host waits for the matching acknowledge before it issues another. A request that arrives while any stage of either shift register is set is dropped. The bridge is then back-pressuring by refusal, so the host must not count on a request seen in that window.

Top module: `lbus_timing_bridge`

## Requirements
- R1: Reset clears both shift registers. While reset is held, and afterwards until a request is accepted, `per_wr`, `per_rd`, `wr_ack`, `rd_ack` and `per_cs` are 0. A transfer cut short by reset never produces an acknowledge.
- R2: On an accepted request, `host_addr` and `host_wdata` are registered. From the cycle after the request edge until the acknowledge cycle ends, `per_addr` and `per_wdata` show those values, whatever the host inputs do in the meantime.
- R3: Call the edge that samples an accepted write request E0. `per_wr` is high in the four cycles that follow edges E1 to E4. It is low in every other cycle.
- R4: `wr_ack` is high in the cycle after E5. That is the first cycle with `per_wr` low again, and address and data are still held during it.
- R5: Each accepted request gives exactly one acknowledge, and that acknowledge is one cycle wide.
- R6: A request arriving while any shift-register stage is set is ignored. This includes the acknowledge cycle. An ignored request adds no strobe and no acknowledge, and it does not change `per_addr`. A request in the cycle after the acknowledge is accepted.
- R7: For an accepted read, `per_rd` is high in the cycles after E1 to E(RD_LEN-2). `rd_ack` is high in the cycle after E(RD_LEN-1). `rd_data` equals the `per_rdata` value present in the cycle just before `rd_ack`, and it keeps that value afterwards.
- R8: If `wr_req` and `rd_req` arrive together while idle, the write is accepted and the read is dropped. `per_rd` and `rd_ack` stay 0.
- R9: With `REG_STROBE` = 1, the strobe comes from a flip-flop fed by the taps one stage earlier. `per_wr` and `per_rd` then have exactly the same timing as with `REG_STROBE` = 0.
- R10: `per_cs` equals the registered `host_cs` from the cycle after the request edge through the acknowledge cycle. It is 0 when idle.
- R11: `per_rst_n` follows `rst_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_req | input | 1 | Write request pulse |
| rd_req | input | 1 | Read request pulse |
| host_addr | input | AW | Host address |
| host_wdata | input | DW | Host write data |
| host_cs | input | 1 | Host chip select for the transfer |
| wr_ack | output | 1 | Write acknowledge, one cycle |
| rd_ack | output | 1 | Read acknowledge, one cycle |
| rd_data | output | DW | Captured read data |
| per_rst_n | output | 1 | Reset to the peripheral |
| per_cs | output | 1 | Peripheral chip select |
| per_wr | output | 1 | Peripheral write strobe, active high |
| per_rd | output | 1 | Peripheral read strobe, active high |
| per_addr | output | AW | Peripheral address |
| per_wdata | output | DW | Peripheral write data |
| per_rdata | input | DW | Peripheral read data |

## Verification
The properties do not assume that requests are well behaved. They rely on the bridge dropping any request made while it is busy, so strobe width, address stability and acknowledge placement must hold even when requests land inside a transfer. The stimulus therefore keeps each request to a single cycle, as the handshake rules ask. It also deliberately places extra requests mid-strobe, in the acknowledge cycle and during a read, to exercise the refusal window. The peripheral model drives a distinctive read value only while `per_rd` is high, so a capture in the wrong cycle shows up as a wrong `rd_data`.

// File: rtl/lbt_pkg.sv
package lbt_pkg;
  // Write-side timing is fixed by tap positions of one shift register.
  localparam int WR_DEPTH   = 6;
  localparam int WR_STB_LO  = 1;
  localparam int WR_STB_HI  = 4;
  localparam int WR_ACK_TAP = WR_DEPTH - 1;

  typedef enum logic [1:0] {
    XFER_IDLE  = 2'd0,
    XFER_WRITE = 2'd1,
    XFER_READ  = 2'd2
  } xfer_e;
endpackage

// File: rtl/lbt_tap_sr.sv
module lbt_tap_sr #(
  parameter int DEPTH = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             din,
  output logic [DEPTH-1:0] taps
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) taps <= '0;
    else        taps <= {taps[DEPTH-2:0], din};
  end
endmodule

// File: rtl/lbt_strobe.sv
module lbt_strobe #(
  parameter int DEPTH      = 6,
  parameter int LO         = 1,
  parameter int HI         = 4,
  parameter bit REGISTERED = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DEPTH-1:0] taps,
  output logic             strobe
);
  generate
    if (REGISTERED) begin : g_reg
      // Decode one stage early, then retime so the output is glitch-free.
      logic early;
      always_comb begin
        early = 1'b0;
        for (int i = 0; i < DEPTH; i++)
          if ((i + 1) >= LO && (i + 1) <= HI) early = early | taps[i];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) strobe <= 1'b0;
        else        strobe <= early;
      end
    end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      always_comb begin
        strobe = 1'b0;
        for (int i = 0; i < DEPTH; i++)
          if (i >= LO && i <= HI) strobe = strobe | taps[i];
      end
    end
  endgenerate
endmodule

// File: rtl/lbt_hold.sv
module lbt_hold #(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_wdata,
  input  logic          host_cs,
  input  logic          grab,
  input  logic [DW-1:0] per_rdata,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] wdata_q,
  output logic          cs_q,
  output logic [DW-1:0] rdata_q
);
  // Transfer attributes freeze on acceptance; they change only on the next one.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      cs_q    <= 1'b0;
    end else if (load) begin
      addr_q  <= host_addr;
      wdata_q <= host_wdata;
      cs_q    <= host_cs;
    end
  end

  // Read data sampled in the cycle before the read acknowledge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    rdata_q <= '0;
    else if (grab) rdata_q <= per_rdata;
  end
endmodule

// File: rtl/lbus_timing_bridge.sv
module lbus_timing_bridge
  import lbt_pkg::*;
#(
  parameter int AW         = 4,
  parameter int DW         = 8,
  parameter int RD_LEN     = 4,
  parameter bit REG_STROBE = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_req,
  input  logic          rd_req,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_wdata,
  input  logic          host_cs,
  output logic          wr_ack,
  output logic          rd_ack,
  output logic [DW-1:0] rd_data,
  output logic          per_rst_n,
  output logic          per_cs,
  output logic          per_wr,
  output logic          per_rd,
  output logic [AW-1:0] per_addr,
  output logic [DW-1:0] per_wdata,
  input  logic [DW-1:0] per_rdata
);
  localparam int RD_ACK_TAP  = RD_LEN - 1;
  localparam int RD_GRAB_TAP = RD_LEN - 2;
  localparam int RD_STB_HI   = RD_LEN - 2;

  logic [WR_DEPTH-1:0] wr_taps;
  logic [RD_LEN-1:0]   rd_taps;
  logic                busy;
  xfer_e               pick;
  logic                cs_q;

  assign busy = (|wr_taps) | (|rd_taps);

  // Write wins a tie; anything arriving while busy is dropped.
  always_comb begin
    pick = XFER_IDLE;
    if (!busy) begin
      if (wr_req)      pick = XFER_WRITE;
      else if (rd_req) pick = XFER_READ;
    end
  end

  lbt_tap_sr #(.DEPTH(WR_DEPTH)) u_wr_sr (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (pick == XFER_WRITE),
    .taps (wr_taps)
  );

  lbt_tap_sr #(.DEPTH(RD_LEN)) u_rd_sr (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (pick == XFER_READ),
    .taps (rd_taps)
  );

  lbt_strobe #(
    .DEPTH(WR_DEPTH), .LO(WR_STB_LO), .HI(WR_STB_HI), .REGISTERED(REG_STROBE)
  ) u_wr_stb (
    .clk   (clk),
    .rst_n (rst_n),
    .taps  (wr_taps),
    .strobe(per_wr)
  );

  lbt_strobe #(
    .DEPTH(RD_LEN), .LO(1), .HI(RD_STB_HI), .REGISTERED(REG_STROBE)
  ) u_rd_stb (
    .clk   (clk),
    .rst_n (rst_n),
    .taps  (rd_taps),
    .strobe(per_rd)
  );

  lbt_hold #(.AW(AW), .DW(DW)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (pick != XFER_IDLE),
    .host_addr (host_addr),
    .host_wdata(host_wdata),
    .host_cs   (host_cs),
    .grab      (rd_taps[RD_GRAB_TAP]),
    .per_rdata (per_rdata),
    .addr_q    (per_addr),
    .wdata_q   (per_wdata),
    .cs_q      (cs_q),
    .rdata_q   (rd_data)
  );

  assign wr_ack    = wr_taps[WR_ACK_TAP];
  assign rd_ack    = rd_taps[RD_ACK_TAP];
  assign per_cs    = cs_q & busy;
  assign per_rst_n = rst_n;
endmodule

// File: rtl/lbt_checker.sv
module lbt_checker #(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          per_wr,
  input logic          per_rd,
  input logic          wr_ack,
  input logic          rd_ack,
  input logic [AW-1:0] per_addr,
  input logic [DW-1:0] per_wdata
);
  logic [2:0] wr_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      wr_run <= '0;
    else if (per_wr) wr_run <= (wr_run == 3'd7) ? wr_run : wr_run + 3'd1;
    else             wr_run <= '0;
  end

  a_r3_strobe_width: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(per_wr) |-> wr_run == 3'd4);

  a_r3_strobe_max: assert property (@(posedge clk) disable iff (!rst_n)
    per_wr |-> wr_run < 3'd4);

  a_r4_ack_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ack |-> !per_wr && $past(per_wr));

  a_r2_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (per_wr || wr_ack) |-> $stable(per_addr) && $stable(per_wdata));

  a_r5_wr_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ack |=> !wr_ack);

  a_r5_rd_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ack |=> !rd_ack);

  a_r7_rd_ack_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ack |-> !per_rd && $past(per_rd));

  a_r8_one_transfer: assert property (@(posedge clk) disable iff (!rst_n)
    !(per_wr && per_rd) && $onehot0({wr_ack, rd_ack}));
endmodule

bind lbus_timing_bridge lbt_checker #(.AW(AW), .DW(DW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .per_wr   (per_wr),
  .per_rd   (per_rd),
  .wr_ack   (wr_ack),
  .rd_ack   (rd_ack),
  .per_addr (per_addr),
  .per_wdata(per_wdata)
);

// File: tb/sim_lbus_timing_bridge.sv
module sim_lbus_timing_bridge;
  localparam int AW = 4;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic          wr_req = 1'b0, rd_req = 1'b0, host_cs = 1'b0;
  logic [AW-1:0] host_addr = '0;
  logic [DW-1:0] host_wdata = '0;
  logic [DW-1:0] salt = '0;

  logic [1:0]    wack, rack, prst, pcs, pwr, prd;
  logic [AW-1:0] paddr [2];
  logic [DW-1:0] pwd [2], rdat [2], prdat [2];

  int  n_chk = 0, n_err = 0;
  bit  done = 1'b0;

  // Peripheral model: distinctive data only while its read strobe is high.
  assign prdat[0] = prd[0] ? ({4'hC, paddr[0]} ^ salt) : 8'hEE;
  assign prdat[1] = prd[1] ? ({4'hC, paddr[1]} ^ salt) : 8'hEE;

  lbus_timing_bridge #(.AW(AW), .DW(DW), .RD_LEN(4), .REG_STROBE(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .rd_req(rd_req),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_cs(host_cs),
    .wr_ack(wack[0]), .rd_ack(rack[0]), .rd_data(rdat[0]), .per_rst_n(prst[0]),
    .per_cs(pcs[0]), .per_wr(pwr[0]), .per_rd(prd[0]), .per_addr(paddr[0]),
    .per_wdata(pwd[0]), .per_rdata(prdat[0]));

  lbus_timing_bridge #(.AW(AW), .DW(DW), .RD_LEN(4), .REG_STROBE(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .rd_req(rd_req),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_cs(host_cs),
    .wr_ack(wack[1]), .rd_ack(rack[1]), .rd_data(rdat[1]), .per_rst_n(prst[1]),
    .per_cs(pcs[1]), .per_wr(pwr[1]), .per_rd(prd[1]), .per_addr(paddr[1]),
    .per_wdata(pwd[1]), .per_rdata(prdat[1]));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Strobe tag: u1 is the registered-strobe variant (R9).
  function automatic string stag(input int i, input string base);
    return (i == 1) ? {base, "/R9"} : base;
  endfunction

  task automatic idle_check(input int n, input string tag);
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      for (int i = 0; i < 2; i++) begin
        chk($sformatf("%s idle u%0d per_wr", tag, i), pwr[i], 0);
        chk($sformatf("%s idle u%0d per_rd", tag, i), prd[i], 0);
        chk($sformatf("%s idle u%0d wr_ack", tag, i), wack[i], 0);
        chk($sformatf("%s idle u%0d rd_ack", tag, i), rack[i], 0);
        chk($sformatf("R10 idle u%0d per_cs", i), pcs[i], 0);
      end
    end
  endtask

  // Write scenario; optional second request injected at cycle inj_k.
  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic cs,
                          input bit with_rd, input int inj_k, input bit inj_rd);
    host_addr = a; host_wdata = d; host_cs = cs; wr_req = 1'b1; rd_req = with_rd;
    for (int k = 1; k <= 7; k++) begin
      @(negedge clk);
      for (int i = 0; i < 2; i++) begin
        chk($sformatf("%s u%0d k%0d per_wr", stag(i, "R3"), i, k), pwr[i], (k >= 2 && k <= 5));
        chk($sformatf("R4 R5 u%0d k%0d wr_ack", i, k), wack[i], (k == 6));
        chk($sformatf("%s u%0d k%0d per_rd", with_rd ? "R8" : "R6", i, k), prd[i], 0);
        chk($sformatf("%s u%0d k%0d rd_ack", with_rd ? "R8" : "R6", i, k), rack[i], 0);
        chk($sformatf("R10 u%0d k%0d per_cs", i, k), pcs[i], (k <= 6) ? cs : 1'b0);
        if (k <= 6) begin
          chk($sformatf("R2 u%0d k%0d per_addr", i, k), paddr[i], a);
          chk($sformatf("R2 u%0d k%0d per_wdata", i, k), pwd[i], d);
        end
      end
      wr_req = 1'b0; rd_req = 1'b0;
      host_addr = ~a; host_wdata = ~d; host_cs = ~cs;
      if (k == inj_k) begin
        if (inj_rd) rd_req = 1'b1;
        else        wr_req = 1'b1;
      end
    end
    if (inj_k != 0) idle_check(3, "R6");
  endtask

  task automatic do_read(input logic [AW-1:0] a, input logic cs, input int inj_k);
    logic [DW-1:0] exp;
    exp = {4'hC, a} ^ salt;
    host_addr = a; host_cs = cs; rd_req = 1'b1;
    for (int k = 1; k <= 5; k++) begin
      @(negedge clk);
      for (int i = 0; i < 2; i++) begin
        chk($sformatf("%s u%0d k%0d per_rd", stag(i, "R7"), i, k), prd[i], (k == 2 || k == 3));
        chk($sformatf("R7 R5 u%0d k%0d rd_ack", i, k), rack[i], (k == 4));
        chk($sformatf("R6 u%0d k%0d per_wr", i, k), pwr[i], 0);
        chk($sformatf("R6 u%0d k%0d wr_ack", i, k), wack[i], 0);
        chk($sformatf("R10 u%0d k%0d per_cs", i, k), pcs[i], (k <= 4) ? cs : 1'b0);
        if (k <= 4) chk($sformatf("R2 u%0d k%0d per_addr", i, k), paddr[i], a);
        if (k >= 4) chk($sformatf("R7 u%0d k%0d rd_data", i, k), rdat[i], exp);
      end
      rd_req = 1'b0; wr_req = 1'b0; host_addr = ~a; host_cs = ~cs;
      if (k == inj_k) wr_req = 1'b1;
    end
    if (inj_k != 0) idle_check(3, "R6");
  endtask

  task automatic reset_check();
    @(negedge clk);
    for (int i = 0; i < 2; i++) begin
      chk($sformatf("R1 reset u%0d per_wr", i), pwr[i], 0);
      chk($sformatf("R1 reset u%0d wr_ack", i), wack[i], 0);
      chk($sformatf("R1 reset u%0d rd_ack", i), rack[i], 0);
      chk($sformatf("R1 reset u%0d per_cs", i), pcs[i], 0);
      chk($sformatf("R11 reset u%0d per_rst_n", i), prst[i], 0);
    end
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 2; i++) chk($sformatf("R11 run u%0d per_rst_n", i), prst[i], 1);
    idle_check(3, "R1");
  endtask

  task automatic reset_mid_write();
    host_addr = 4'h2; host_wdata = 8'h44; host_cs = 1'b1; wr_req = 1'b1;
    @(negedge clk); wr_req = 1'b0;
    @(negedge clk);
    @(negedge clk);
    for (int i = 0; i < 2; i++) chk($sformatf("R3 pre-reset u%0d per_wr", i), pwr[i], 1);
    rst_n = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 2; i++) begin
      chk($sformatf("R1 mid-reset u%0d per_wr", i), pwr[i], 0);
      chk($sformatf("R11 mid-reset u%0d per_rst_n", i), prst[i], 0);
    end
    rst_n = 1'b1;
    idle_check(8, "R1");
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    reset_check();
    do_write(4'h3, 8'h5A, 1'b1, 1'b0, 0, 1'b0);
    do_write(4'hC, 8'hA3, 1'b1, 1'b0, 0, 1'b0);   // R6: accepted right after ack
    do_write(4'h9, 8'h0F, 1'b0, 1'b0, 0, 1'b0);   // R10: chip select low
    do_write(4'h6, 8'h71, 1'b1, 1'b0, 3, 1'b0);   // R6: write during strobe
    do_write(4'h1, 8'hE2, 1'b1, 1'b0, 6, 1'b0);   // R6: write in ack cycle
    do_write(4'h7, 8'h33, 1'b1, 1'b0, 4, 1'b1);   // R6: read during write
    salt = 8'h00;
    do_read(4'h5, 1'b1, 0);
    salt = 8'h3C;
    do_read(4'hA, 1'b1, 2);                       // R6: write during read
    do_write(4'hB, 8'h99, 1'b1, 1'b1, 0, 1'b0);   // R8: simultaneous requests
    idle_check(2, "R8");
    reset_mid_write();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule